// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block connects a synchronous requester to an external 8,192 x 8 asynchronous static RAM. The requester raises a one-cycle request strobe together with a direction bit, a 13-bit word address and a write byte. The block captures these values, runs the memory strobes for one complete access, and then returns a single-cycle completion pulse. On a read, the completion pulse comes with the captured byte. Between accesses the memory is kept in standby.

The memory has two chip enables of opposite polarity, an active-low output enable and an active-low write enable. The shared data bus appears as three separate signals: an outgoing byte, a drive-enable and an incoming byte. The top level combines them into the pad. Each phase lasts a whole number of system clocks. That number is worked out during elaboration from the clock period and the timing set of the chosen speed grade. A write leaves the data bus undriven until the memory has had time to release it. The block drives the bus only for the final stretch of the write pulse and for one hold cycle after it.

Top module: `sram_ctl`

## Requirements
- R1: After reset, and whenever no access is running, the block holds the memory in standby: `mem_ce_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, and `done`=0.
- R2: A read (`req_we`=0) holds `mem_ce_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD = ceil(max(tRC,tOE)/CLK_NS) cycles. For the fast grade tRC=35 ns and tOE=25 ns.
- R3: On the last read cycle the block samples `mem_dq_i` and presents it on `rd_data` together with `done`.
- R4: A write (`req_we`=1) holds `mem_we_n`=0 for exactly WE = max(ceil(max(tWP,tAW,tWC)/CLK_NS), TA+ceil(tDW/CLK_NS)) cycles. `mem_oe_n` stays 1 for the whole write. For the fast grade tWP=25, tAW=30, tWC=35 and tDW=20 ns.
- R5: For the first TA = ceil(tWHZ/CLK_NS) cycles of the write pulse, `mem_dq_oe` is 0. For the fast grade tWHZ=15 ns.
- R6: `mem_dq_oe` is 1 for the remaining WE-TA cycles of the write pulse. It then stays 1 for one hold cycle after `mem_we_n` rises, while both chip enables stay asserted. The memory stores the driven byte.
- R7: Throughout an access, `mem_addr` holds the address given at acceptance. While it is driven, `mem_dq_o` holds the write byte given at acceptance.
- R8: `done` is a one-cycle pulse. Counting from the clock edge that accepts the request, it rises RD edges later for a read and WE+1 edges later for a write.
- R9: A request raised while an access is running is ignored. It produces no memory cycle and no `done`.
- R10: With `SLOW_GRADE`=1 the slow timing set is used: tRC=tWC=70, tOE=35, tAW=60, tWP=50, tDW=30 and tWHZ=25 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken only when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| rd_data | output | DATA_W | Byte captured by the last read |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | DATA_W | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | DATA_W | Byte read from the data bus |

## Verification
The bench builds two instances with CLK_NS=4. The first uses the fast grade, which gives RD=9, TA=4 and WE=9. In that case the write pulse length is set equally by the cycle time and by turnaround plus data setup. The second instance uses `SLOW_GRADE`=1, which gives RD=18, TA=7 and WE=18. These figures reach the case where the turnaround and setup sum (15) is smaller than the cycle bound. The memory model on each instance returns a junk byte until the output enable has been low for the full access window. An early capture therefore shows up as a data mismatch.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR_TA,
        ST_WR_DATA,
        ST_WR_HOLD
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic ce2;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } strobe_t;

    typedef struct packed {
        int t_rc;
        int t_oe;
        int t_wc;
        int t_aw;
        int t_wp;
        int t_dw;
        int t_whz;
    } grade_t;

    function automatic grade_t grade_timing(input bit slow);
        grade_t g;
        g.t_rc  = slow ? 70 : 35;
        g.t_oe  = slow ? 35 : 25;
        g.t_wc  = slow ? 70 : 35;
        g.t_aw  = slow ? 60 : 30;
        g.t_wp  = slow ? 50 : 25;
        g.t_dw  = slow ? 30 : 20;
        g.t_whz = slow ? 25 : 15;
        return g;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // whole clocks covering ns, never below one
    function automatic int cycles_for(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC = 9,
    parameter int TA_CYC = 4,
    parameter int DP_CYC = 5,
    parameter int CNT_W  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       req_we,
    output seq_state_e state,
    output logic       accept,
    output logic       capture,
    output logic       done
);

    logic [CNT_W-1:0] cnt;
    logic             expired;

    assign expired = (cnt == '0);
    assign accept  = (state == ST_IDLE) && req;
    assign capture = (state == ST_RD) && expired;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req) begin
                        if (req_we) begin
                            state <= ST_WR_TA;
                            cnt   <= CNT_W'(TA_CYC - 1);
                        end else begin
                            state <= ST_RD;
                            cnt   <= CNT_W'(RD_CYC - 1);
                        end
                    end
                end
                ST_RD: begin
                    if (expired) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_WR_TA: begin
                    if (expired) begin
                        state <= ST_WR_DATA;
                        cnt   <= CNT_W'(DP_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_WR_DATA: begin
                    if (expired) state <= ST_WR_HOLD;
                    else         cnt   <= cnt - 1'b1;
                end
                ST_WR_HOLD: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sram_ctl_strobe.sv
module sram_ctl_strobe
    import sram_ctl_pkg::*;
(
    input  seq_state_e state,
    output strobe_t    strb
);

    always_comb begin
        strb = '{ce_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
        unique case (state)
            ST_RD:      strb = '{ce_n: 1'b0, ce2: 1'b1, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
            ST_WR_TA:   strb = '{ce_n: 1'b0, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b0};
            ST_WR_DATA: strb = '{ce_n: 1'b0, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
            ST_WR_HOLD: strb = '{ce_n: 1'b0, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
            default:    ;
        endcase
    end

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                mem_addr <= req_addr;
                mem_dq_o <= req_wdata;
            end
            if (capture) rd_data <= mem_dq_i;
        end
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int CLK_NS     = 4,
    parameter bit SLOW_GRADE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam grade_t TM     = grade_timing(SLOW_GRADE);
    localparam int     RD_CYC = cycles_for(imax(TM.t_rc, TM.t_oe), CLK_NS);
    localparam int     TA_CYC = cycles_for(TM.t_whz, CLK_NS);
    localparam int     SU_CYC = cycles_for(TM.t_dw, CLK_NS);
    localparam int     WE_CYC = imax(cycles_for(imax(imax(TM.t_wp, TM.t_aw), TM.t_wc), CLK_NS),
                                     TA_CYC + SU_CYC);
    localparam int     DP_CYC = WE_CYC - TA_CYC;
    localparam int     CNT_W  = $clog2(imax(RD_CYC, imax(TA_CYC, DP_CYC)) + 1);

    seq_state_e state;
    strobe_t    strb;
    logic       accept;
    logic       capture;

    sram_ctl_seq #(
        .RD_CYC (RD_CYC),
        .TA_CYC (TA_CYC),
        .DP_CYC (DP_CYC),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .req_we  (req_we),
        .state   (state),
        .accept  (accept),
        .capture (capture),
        .done    (done)
    );

    sram_ctl_strobe u_strobe (
        .state (state),
        .strb  (strb)
    );

    sram_ctl_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_i  (mem_dq_i),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .rd_data   (rd_data)
    );

    assign mem_ce_n  = strb.ce_n;
    assign mem_ce2   = strb.ce2;
    assign mem_oe_n  = strb.oe_n;
    assign mem_we_n  = strb.we_n;
    assign mem_dq_oe = strb.dq_oe;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_ce_n,
    input logic              mem_ce2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr
);

    p_standby_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_ce_n || !mem_ce2) |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

    p_no_oe_in_write_r4: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    p_turnaround_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> !mem_dq_oe);

    p_hold_after_we_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && mem_ce2));

    p_addr_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_ce_n  (mem_ce_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .done      (done),
    .mem_addr  (mem_addr)
);

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb_mem #(
    parameter int    RD_CYC = 9,
    parameter int    TA_CYC = 4,
    parameter int    WE_CYC = 9,
    parameter string NAME   = "fast"
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [12:0] addr,
    input  logic       ce_n,
    input  logic       ce2,
    input  logic       oe_n,
    input  logic       we_n,
    input  logic [7:0] dq_o,
    input  logic       dq_oe,
    output logic [7:0] dq_i,
    output int         n_chk,
    output int         n_fail
);

    logic [7:0]  store [logic [12:0]];
    int          rd_run = 0;
    int          we_run = 0;
    int          drv_run = 0;
    int          first_drv = 0;
    logic        prev_rd = 1'b0;
    logic        prev_we = 1'b0;
    logic        in_txn = 1'b0;
    logic [12:0] txn_addr = '0;
    logic [7:0]  drv_data = '0;
    logic        en;
    logic        rd_act;

    assign en     = !ce_n && ce2;
    assign rd_act = en && !oe_n && we_n;

    always @* begin
        if (rd_act && rd_run >= RD_CYC)
            dq_i = store.exists(addr) ? store[addr] : 8'h00;
        else
            dq_i = 8'hA5;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, NAME, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!en) begin
                chk(oe_n && we_n && !dq_oe, "R1 standby strobes",
                    int'({oe_n, we_n, dq_oe}), 6);
                in_txn = 1'b0;
            end else if (!in_txn) begin
                in_txn   = 1'b1;
                txn_addr = addr;
            end else begin
                chk(addr == txn_addr, "R7 address stable", int'(addr), int'(txn_addr));
            end

            if (rd_act) begin
                rd_run++;
            end else if (prev_rd) begin
                chk(rd_run == RD_CYC, "R2 read strobe length", rd_run, RD_CYC);
                rd_run = 0;
            end

            if (en && !we_n) begin
                chk(oe_n, "R4 output enable off in write", int'(oe_n), 1);
                we_run++;
                if (dq_oe) begin
                    if (drv_run == 0) first_drv = we_run - 1;
                    drv_run++;
                    if (drv_run > 1)
                        chk(dq_o == drv_data, "R7 write byte stable", int'(dq_o), int'(drv_data));
                    drv_data = dq_o;
                end
            end else if (prev_we) begin
                chk(we_run == WE_CYC, "R4 write pulse length", we_run, WE_CYC);
                chk(first_drv == TA_CYC, "R5 turnaround before drive", first_drv, TA_CYC);
                chk(drv_run == WE_CYC - TA_CYC, "R6 driven cycles in pulse", drv_run, WE_CYC - TA_CYC);
                chk(en && dq_oe, "R6 hold cycle drive", int'({en, dq_oe}), 3);
                chk(dq_o == drv_data, "R7 byte in hold cycle", int'(dq_o), int'(drv_data));
                store[addr] = dq_o;
                we_run  = 0;
                drv_run = 0;
            end
            prev_rd = rd_act;
            prev_we = en && !we_n;
        end
    end

endmodule

module sram_ctl_tb;

    localparam int CLK_NS = 4;

    function automatic int cdiv(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int F_RD = cdiv(mx(35, 25));
    localparam int F_TA = cdiv(15);
    localparam int F_WE = mx(cdiv(mx(mx(25, 30), 35)), F_TA + cdiv(20));
    localparam int S_RD = cdiv(mx(70, 35));
    localparam int S_TA = cdiv(25);
    localparam int S_WE = mx(cdiv(mx(mx(50, 60), 70)), S_TA + cdiv(30));

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_NS / 2) clk = ~clk;

    // fast instance
    logic        req = 1'b0, req_we = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rd_data, mem_dq_o, mem_dq_i;
    logic        done, mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [12:0] mem_addr;

    // slow instance
    logic        s_req = 1'b0, s_req_we = 1'b0;
    logic [12:0] s_req_addr = '0;
    logic [7:0]  s_req_wdata = '0;
    logic [7:0]  s_rd_data, s_dq_o, s_dq_i;
    logic        s_done, s_ce_n, s_ce2, s_oe_n, s_we_n, s_dq_oe;
    logic [12:0] s_addr;

    int mf_chk, mf_fail, ms_chk, ms_fail;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    sram_ctl #(.CLK_NS(CLK_NS), .SLOW_GRADE(1'b0)) u_dut (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .done(done), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

    sram_ctl_tb_mem #(.RD_CYC(F_RD), .TA_CYC(F_TA), .WE_CYC(F_WE), .NAME("fast")) u_mem_f (
        .clk(clk), .rst(rst), .addr(mem_addr), .ce_n(mem_ce_n), .ce2(mem_ce2),
        .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_o(mem_dq_o), .dq_oe(mem_dq_oe),
        .dq_i(mem_dq_i), .n_chk(mf_chk), .n_fail(mf_fail));

    sram_ctl #(.CLK_NS(CLK_NS), .SLOW_GRADE(1'b1)) u_dut_slow (
        .clk(clk), .rst(rst), .req(s_req), .req_we(s_req_we), .req_addr(s_req_addr),
        .req_wdata(s_req_wdata), .rd_data(s_rd_data), .done(s_done), .mem_addr(s_addr),
        .mem_ce_n(s_ce_n), .mem_ce2(s_ce2), .mem_oe_n(s_oe_n), .mem_we_n(s_we_n),
        .mem_dq_o(s_dq_o), .mem_dq_oe(s_dq_oe), .mem_dq_i(s_dq_i));

    sram_ctl_tb_mem #(.RD_CYC(S_RD), .TA_CYC(S_TA), .WE_CYC(S_WE), .NAME("slow R10")) u_mem_s (
        .clk(clk), .rst(rst), .addr(s_addr), .ce_n(s_ce_n), .ce2(s_ce2),
        .oe_n(s_oe_n), .we_n(s_we_n), .dq_o(s_dq_o), .dq_oe(s_dq_oe),
        .dq_i(s_dq_i), .n_chk(ms_chk), .n_fail(ms_fail));

    typedef struct {
        bit         is_rd;
        logic [7:0] data;
    } exp_t;

    exp_t       sb_q[$];
    logic [7:0] ref_mem [logic [12:0]];
    logic       prev_done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        int total, bad;
        if (!finished) begin
            finished = 1;
            total = n_chk + mf_chk + ms_chk;
            bad   = n_fail + mf_fail + ms_fail;
            $display("%0d/%0d checks passed", total - bad, total);
            $finish;
        end
    endtask

    function automatic logic [7:0] ref_rd(input logic [12:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (done && prev_done)
                check(0, "R8 done longer than one cycle", 2, 1);
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(0, "R9 unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (e.is_rd)
                        check(rd_data == e.data, "R3 read data", int'(rd_data), int'(e.data));
                end
            end
            prev_done = done;
        end
    end

    // driver: one access on the fast instance, optional request while busy
    task automatic txn(input bit we, input logic [12:0] a, input logic [7:0] d,
                       input bit poke, input logic [12:0] pa, input logic [7:0] pd);
        int lat;
        exp_t e;
        e.is_rd = !we;
        e.data  = we ? 8'h00 : ref_rd(a);
        sb_q.push_back(e);
        if (we) ref_mem[a] = d;
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1) begin
                req = poke;
                req_we = 1'b1; req_addr = pa; req_wdata = pd;
            end else if (lat == 2) begin
                req = 1'b0;
            end
        end while (!done && lat < 500);
        req = 1'b0;
        check(lat == (we ? F_WE + 2 : F_RD + 1), "R8 completion latency", lat,
              we ? F_WE + 2 : F_RD + 1);
        @(negedge clk);
    endtask

    task automatic slow_txn(input bit we, input logic [12:0] a, input logic [7:0] d,
                            input logic [7:0] exp_rd);
        int lat;
        s_req = 1'b1; s_req_we = we; s_req_addr = a; s_req_wdata = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1) s_req = 1'b0;
        end while (!s_done && lat < 500);
        check(lat == (we ? S_WE + 2 : S_RD + 1), "R10 slow completion latency", lat,
              we ? S_WE + 2 : S_RD + 1);
        if (!we)
            check(s_rd_data == exp_rd, "R10 slow read data", int'(s_rd_data), int'(exp_rd));
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe && !done,
              "R1 reset state", int'({mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, done}),
              6'b101100);

        txn(1'b1, 13'h0000, 8'h3C, 1'b0, '0, '0);
        txn(1'b1, 13'h1FFF, 8'hC3, 1'b0, '0, '0);
        txn(1'b1, 13'h0AAA, 8'h55, 1'b0, '0, '0);
        txn(1'b1, 13'h1555, 8'hAA, 1'b0, '0, '0);
        txn(1'b0, 13'h0000, 8'h00, 1'b0, '0, '0);
        txn(1'b0, 13'h1FFF, 8'h00, 1'b0, '0, '0);
        txn(1'b0, 13'h1555, 8'h00, 1'b0, '0, '0);
        txn(1'b0, 13'h0100, 8'h00, 1'b0, '0, '0);
        // R9: write request raised during a read must be dropped
        txn(1'b0, 13'h0AAA, 8'h00, 1'b1, 13'h0AAA, 8'hFF);
        txn(1'b0, 13'h0AAA, 8'h00, 1'b0, '0, '0);
        // R9: write request raised during a write must be dropped
        txn(1'b1, 13'h0000, 8'h7E, 1'b1, 13'h1555, 8'h11);
        txn(1'b0, 13'h0000, 8'h00, 1'b0, '0, '0);
        txn(1'b0, 13'h1555, 8'h00, 1'b0, '0, '0);

        repeat (20) @(negedge clk);
        check(sb_q.size() == 0, "R8 every access completed", sb_q.size(), 0);

        slow_txn(1'b1, 13'h1234, 8'h9B, 8'h00);
        slow_txn(1'b1, 13'h0001, 8'h42, 8'h00);
        slow_txn(1'b0, 13'h1234, 8'h00, 8'h9B);
        slow_txn(1'b0, 13'h0001, 8'h00, 8'h42);

        repeat (5) @(negedge clk);
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 1, 0);
        report();
    end

endmodule